// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block is the sending half of a clocked serial port. Software programs a control byte and then writes transmit bytes into a one-byte holding register. When the shifter is free and nothing blocks it, the waiting byte moves into an 8-bit shift register. The holding register then reports empty again, so the next byte can be queued while the current one is still going out. Frames are sent MSB first. A queued byte is picked up at the end of the current frame, so back-to-back frames run with no extra clock gap.

As clock master, the block makes the serial clock from the system clock with a programmable divider. As slave, it follows an external serial clock, and only while an external active-low select is asserted. Both of those inputs are resynchronised into the system clock domain. Two flags, holding-register empty and transmission finished, drive one shared interrupt line through separate enables. A pending overrun condition from the receive side stops any new frame from starting.

Top module: `sertx_top`

## Requirements
- R1: After synchronous reset the outputs are: empty flag 1, end flag 0, overrun flag 0, interrupt 0, serial clock output 0 and serial data output 0.
- R2: Register address 1 is the transmit data register. A write there while transmit-enable is 1 queues the byte and drives the empty flag to 0 in the next cycle. If the shifter is idle, the byte moves into the shifter one cycle later and the empty flag returns to 1. A write there while transmit-enable is 0 is ignored: the empty flag stays 1 and no clock edge appears.
- R3: Each frame has 8 bits, MSB first. The data output changes on the clock edge that leaves the idle level and holds steady across the following edge back to the idle level.
- R4: Register address 0 is the control byte, laid out as follows: bit 0 transmit-enable, bit 1 master (1) or slave (0), bit 2 clock polarity, bits 5:3 divider code d, bit 6 empty-interrupt enable, bit 7 end-interrupt enable. In master mode the serial clock period is N = 4·2^d system clocks. The first leading edge comes N/2 cycles after the byte enters the shifter.
- R5: If a byte is queued when the 8th bit of a frame completes, it is loaded at once. The next frame's first leading edge then follows the last trailing edge after N/2 cycles, the same spacing as inside a frame.
- R6: Register address 2 is the status register. The end flag is set exactly when the 8th bit completes with no byte queued, and it stays set. Writing 0 to status bit 0, or writing a byte to the data register, clears it. Writing 1 to status bit 0 has no effect.
- R7: The interrupt output equals (empty flag AND bit 6 of the control byte) OR (end flag AND bit 7 of the control byte).
- R8: While no frame is in progress, the serial clock output rests at the clock-polarity bit: low for 0, high for 1.
- R9: A pulse on the overrun input sets the overrun flag. Writing 0 to status bit 1 clears it. While the flag is 1, no frame starts, and a queued byte stays queued with the empty flag at 0. Once the flag is cleared, the queued byte is sent.
- R10: In slave mode the external clock and select are each synchronised through two flip-flops. Bits shift only on external clock edges that occur while the select is low. The serial clock output stays at the clock-polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| wr_data | input | 8 | Register write data |
| ovr_set | input | 1 | Overrun pulse from the receive side |
| sck_in | input | 1 | External serial clock (slave mode) |
| cs_n_in | input | 1 | External active-low select (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sdo_out | output | 1 | Serial data output |
| empty_flag | output | 1 | Holding register empty |
| end_flag | output | 1 | Transmission finished, latched |
| ovr_flag | output | 1 | Overrun pending |
| irq_tx | output | 1 | Shared transmit interrupt request |

## Verification
A wrong bit counter or shift register shows up as a wrong byte, or as a wrong number of trailing edges, within one frame. A faulty divider or phase register shows up on the first lead-edge interval, which is N system clocks. A lost or extra queued-byte state shows in one of two ways. Either the end flag is already set at the 8th trailing edge of a chained pair, or the second frame never appears. Both are visible within two frame times. A stuck overrun gate shows as clock edges while the flag is set. A broken slave synchroniser shows as a wrong byte at the first external pulses.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int DIV_W       = 3;
    localparam int SYNC_STAGES = 2;
    localparam int MAX_HALF    = 2 << ((1 << DIV_W) - 1);
    localparam int CNT_W       = $clog2(MAX_HALF + 1);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic             ie_end;
        logic             ie_empty;
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             master;
        logic             tx_en;
    } ctrl_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } edge_t;

    function automatic logic [CNT_W-1:0] half_period(input logic [DIV_W-1:0] d);
        return CNT_W'(2) << d;
    endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovr_set,
    input  logic              load_i,
    input  logic              end_set_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] hold_o,
    output logic              empty_o,
    output logic              end_o,
    output logic              ovr_o,
    output logic              irq_o
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic              empty_q;
    logic              end_q;
    logic              ovr_q;
    logic              data_wr;
    logic              stat_wr;
    logic              ctrl_wr;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        data_wr = wr_en && (wr_addr == ADDR_DATA) && ctrl_q.tx_en;
        stat_wr = wr_en && (wr_addr == ADDR_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else if (data_wr) begin
            hold_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (load_i) begin
            empty_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            end_q <= 1'b0;
        end else if (data_wr) begin
            end_q <= 1'b0;
        end else if (stat_wr && !wr_data[0]) begin
            end_q <= 1'b0;
        end else if (end_set_i) begin
            end_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (ovr_set) begin
            ovr_q <= 1'b1;
        end else if (stat_wr && !wr_data[1]) begin
            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_o  = ctrl_q;
        hold_o  = hold_q;
        empty_o = empty_q;
        end_o   = end_q;
        ovr_o   = ovr_q;
        irq_o   = (empty_q && ctrl_q.ie_empty) || (end_q && ctrl_q.ie_end);
    end

    assert_ignored_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_DATA && !ctrl_q.tx_en && empty_q) |=> empty_q);

    assert_load_needs_data_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !empty_q);

    assert_end_only_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        end_set_i |-> empty_q);

    assert_end_cleared_by_data_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_DATA && ctrl_q.tx_en) |=> !end_q);

endmodule

// File: rtl/sertx_clkgen.sv
module sertx_clkgen
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             master_i,
    input  logic             cpol_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             busy_i,
    input  logic             start_i,
    input  logic             sck_in,
    input  logic             cs_n_in,
    output edge_t            edges_o,
    output logic             sck_o
);

    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       half;
    logic                   next_lead;
    logic                   sck_lvl;
    logic                   tick;
    logic [SYNC_STAGES-1:0] sck_sync;
    logic [SYNC_STAGES-1:0] cs_sync;
    logic                   sck_prev;
    logic                   ext_rise;
    logic                   ext_fall;
    logic                   slave_act;

    always_comb begin
        half = half_period(div_i);
        tick = busy_i && master_i && (cnt == half - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            next_lead <= 1'b1;
            sck_lvl   <= 1'b0;
        end else if (start_i) begin
            cnt       <= '0;
            next_lead <= 1'b1;
            sck_lvl   <= cpol_i;
        end else if (busy_i && master_i) begin
            if (tick) begin
                cnt       <= '0;
                next_lead <= !next_lead;
                sck_lvl   <= next_lead ? !cpol_i : cpol_i;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else begin
            cnt       <= '0;
            next_lead <= 1'b1;
            sck_lvl   <= cpol_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sync[g] <= 1'b0;
                    cs_sync[g]  <= 1'b1;
                end else if (g == 0) begin
                    sck_sync[g] <= sck_in;
                    cs_sync[g]  <= cs_n_in;
                end else begin
                    sck_sync[g] <= sck_sync[g-1];
                    cs_sync[g]  <= cs_sync[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_sync[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ext_rise  = sck_sync[SYNC_STAGES-1] && !sck_prev;
        ext_fall  = !sck_sync[SYNC_STAGES-1] && sck_prev;
        slave_act = busy_i && !master_i && !cs_sync[SYNC_STAGES-1];
        if (master_i) begin
            edges_o.lead  = tick && next_lead;
            edges_o.trail = tick && !next_lead;
        end else begin
            edges_o.lead  = slave_act && (cpol_i ? ext_fall : ext_rise);
            edges_o.trail = slave_act && (cpol_i ? ext_rise : ext_fall);
        end
        sck_o = (master_i && busy_i) ? sck_lvl : cpol_i;
    end

    assert_sck_moves_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (master_i && busy_i && $past(busy_i) && $stable(cpol_i) && (sck_lvl != $past(sck_lvl)))
        |-> (cnt == '0));

    assert_idle_level_at_end_R8: assert property (@(posedge clk) disable iff (rst)
        (master_i && $fell(busy_i) && $stable(cpol_i)) |-> (sck_lvl == cpol_i));

    assert_single_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(edges_o));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_t            edges_i,
    input  logic [WIDTH-1:0] hold_i,
    input  logic             empty_i,
    input  logic             ovr_i,
    output logic             load_o,
    output logic             start_o,
    output logic             end_set_o,
    output logic             busy_o,
    output logic             sdo_o
);

    localparam int BC_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] sh;
    logic [BC_W-1:0]  bitcnt;
    logic             busy;
    logic             sdo;
    logic             pending;
    logic             done;

    always_comb begin
        pending   = !empty_i && !ovr_i;
        done      = busy && edges_i.trail && (bitcnt == BC_W'(WIDTH - 1));
        load_o    = pending && (!busy || done);
        start_o   = pending && !busy;
        end_set_o = done && empty_i;
        busy_o    = busy;
        sdo_o     = sdo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            bitcnt <= '0;
            busy   <= 1'b0;
            sdo    <= 1'b0;
        end else if (load_o) begin
            sh     <= hold_i;
            bitcnt <= '0;
            busy   <= 1'b1;
        end else if (done) begin
            bitcnt <= '0;
            busy   <= 1'b0;
        end else if (busy) begin
            if (edges_i.lead) begin
                sdo <= sh[WIDTH-1];
                sh  <= {sh[WIDTH-2:0], 1'b0};
            end
            if (edges_i.trail) begin
                bitcnt <= bitcnt + BC_W'(1);
            end
        end
    end

    assert_chain_continues_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !empty_i && !ovr_i) |=> busy);

    assert_overrun_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (ovr_i && !busy) |=> !busy);

    assert_bit_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bitcnt < BC_W'(WIDTH)));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovr_set,
    input  logic              sck_in,
    input  logic              cs_n_in,
    output logic              sck_out,
    output logic              sdo_out,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              ovr_flag,
    output logic              irq_tx
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] hold;
    logic              load;
    logic              start;
    logic              end_set;
    logic              busy;
    edge_t             edges;

    sertx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ovr_set   (ovr_set),
        .load_i    (load),
        .end_set_i (end_set),
        .ctrl_o    (ctrl),
        .hold_o    (hold),
        .empty_o   (empty_flag),
        .end_o     (end_flag),
        .ovr_o     (ovr_flag),
        .irq_o     (irq_tx)
    );

    sertx_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .master_i (ctrl.master),
        .cpol_i   (ctrl.cpol),
        .div_i    (ctrl.div),
        .busy_i   (busy),
        .start_i  (start),
        .sck_in   (sck_in),
        .cs_n_in  (cs_n_in),
        .edges_o  (edges),
        .sck_o    (sck_out)
    );

    sertx_shift #(.WIDTH(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .edges_i   (edges),
        .hold_i    (hold),
        .empty_i   (empty_flag),
        .ovr_i     (ovr_flag),
        .load_o    (load),
        .start_o   (start),
        .end_set_o (end_set),
        .busy_o    (busy),
        .sdo_o     (sdo_out)
    );

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ovr_set = 1'b0;
    logic       sck_in = 1'b0;
    logic       cs_n_in = 1'b1;
    logic       sck_out, sdo_out, empty_flag, end_flag, ovr_flag, irq_tx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ovr_set(ovr_set), .sck_in(sck_in), .cs_n_in(cs_n_in), .sck_out(sck_out),
        .sdo_out(sdo_out), .empty_flag(empty_flag), .end_flag(end_flag),
        .ovr_flag(ovr_flag), .irq_tx(irq_tx)
    );

    // Serial line monitor (master mode)
    int          mon_gen = 0;
    int          seen_gen = 0;
    int          nbits = 0;
    int          bad = 0;
    logic [31:0] cap = '0;
    logic        have_lead = 1'b0;
    logic        end_at8 = 1'b0;
    logic        prev_sck = 1'b0;
    logic        cpol_b = 1'b0;
    time         exp_per_ns = 0;
    time         first_lead_t = 0;
    time         last_lead_t = 0;
    time         last_wr_t = 0;

    always @(negedge clk) begin
        if (mon_gen != seen_gen) begin
            seen_gen  = mon_gen;
            nbits     = 0;
            bad       = 0;
            cap       = '0;
            have_lead = 1'b0;
            end_at8   = 1'b0;
        end else if (sck_out != prev_sck) begin
            if (sck_out != cpol_b) begin
                if (have_lead) begin
                    if ($time - last_lead_t != exp_per_ns) bad = bad + 1;
                end else begin
                    first_lead_t = $time;
                end
                have_lead   = 1'b1;
                last_lead_t = $time;
            end else begin
                cap   = {cap[30:0], sdo_out};
                nbits = nbits + 1;
                if (nbits == 8) end_at8 = end_flag;
            end
        end
        prev_sck = sck_out;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        last_wr_t = $time;
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mon_reset(input logic cp, input int per_cycles);
        cpol_b     = cp;
        exp_per_ns = time'(per_cycles * 4);
        mon_gen++;
        idle(2);
    endtask

    task automatic wait_end(input int limit);
        int n = 0;
        while (!end_flag && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [7:0] ctrl_byte(input logic ie_end, input logic ie_empty,
                                             input logic [2:0] d, input logic cp,
                                             input logic mst, input logic en);
        return {ie_end, ie_empty, d, cp, mst, en};
    endfunction

    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [7:0] b2;
        logic [7:0] sl;
        int h;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 empty", int'(empty_flag), 1);
        check("R1 end", int'(end_flag), 0);
        check("R1 ovr", int'(ovr_flag), 0);
        check("R1 irq", int'(irq_tx), 0);
        check("R1 sck", int'(sck_out), 0);
        check("R1 sdo", int'(sdo_out), 0);

        // R2 write ignored while transmit-enable is 0
        wr(2'd0, ctrl_byte(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0));
        mon_reset(1'b0, 4);
        wr(2'd1, 8'h5A);
        check("R2 ignored write empty", int'(empty_flag), 1);
        idle(100);
        check("R2 ignored write no edges", nbits + int'(have_lead), 0);

        // R2/R3/R4/R6/R7/R8 sweep of divider and polarity
        for (int d = 0; d < 8; d++) begin
            for (int cp = 0; cp < 2; cp++) begin
                b = 8'((d * 53) ^ (cp != 0 ? 8'hC3 : 8'h5A));
                h = 2 << d;
                wr(2'd0, ctrl_byte(1'b1, 1'b0, 3'(d), cp[0], 1'b1, 1'b1));
                idle(2);
                mon_reset(cp[0], 4 << d);
                check("R8 idle level", int'(sck_out), cp);
                wr(2'd1, b);
                check("R2 empty low after write", int'(empty_flag), 0);
                idle(1);
                check("R2 empty high after load", int'(empty_flag), 1);
                wait_end(6000);
                idle(1);
                check("R3 bit count", nbits, 8);
                check("R3 byte MSB first", int'(cap[7:0]), int'(b));
                check("R4 period", bad, 0);
                check("R4 first edge delay", int'(first_lead_t - last_wr_t), 8 + 4 * h);
                check("R6 end at 8th bit", int'(end_at8), 1);
                check("R7 irq end enabled", int'(irq_tx), 1);
                check("R8 level after frame", int'(sck_out), cp);
                wr(2'd2, 8'h01);
                check("R6 write 1 no effect", int'(end_flag), 1);
                wr(2'd2, 8'h00);
                check("R6 write 0 clears", int'(end_flag), 0);
                check("R7 irq drops", int'(irq_tx), 0);
            end
        end

        // R5 chained frames without gap
        wr(2'd0, ctrl_byte(1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1));
        idle(2);
        mon_reset(1'b0, 8);
        b  = 8'h96;
        b2 = 8'h3B;
        wr(2'd1, b);
        idle(1);
        wr(2'd1, b2);
        check("R5 second byte queued", int'(empty_flag), 0);
        wait_end(2000);
        idle(1);
        check("R5 bit count", nbits, 16);
        check("R5 two bytes", int'(cap[15:0]), int'({b, b2}));
        check("R5 no gap", bad, 0);
        check("R5 no end between frames", int'(end_at8), 0);
        check("R6 end after chain", int'(end_flag), 1);
        // R6 data write clears end flag
        wr(2'd1, 8'hE1);
        check("R6 data write clears end", int'(end_flag), 0);
        wait_end(2000);
        wr(2'd2, 8'h00);

        // R9 overrun blocks transmission
        wr(2'd0, ctrl_byte(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1));
        idle(2);
        @(negedge clk);
        ovr_set = 1'b1;
        @(negedge clk);
        ovr_set = 1'b0;
        check("R9 flag set", int'(ovr_flag), 1);
        mon_reset(1'b0, 4);
        wr(2'd1, 8'h3C);
        idle(200);
        check("R9 no edges", nbits + int'(have_lead), 0);
        check("R9 byte stays queued", int'(empty_flag), 0);
        wr(2'd2, 8'h01);
        check("R9 flag cleared", int'(ovr_flag), 0);
        wait_end(2000);
        idle(1);
        check("R9 byte after clear", int'(cap[7:0]), 8'h3C);
        wr(2'd2, 8'h00);

        // R7 empty interrupt enable
        wr(2'd0, ctrl_byte(1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1));
        idle(1);
        check("R7 irq on empty", int'(irq_tx), 1);
        wr(2'd1, 8'h11);
        check("R7 irq low while queued", int'(irq_tx), 0);
        wait_end(2000);
        wr(2'd0, ctrl_byte(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1));
        check("R7 irq both disabled", int'(irq_tx), 0);
        wr(2'd0, ctrl_byte(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1));
        check("R7 irq end only", int'(irq_tx), 1);
        wr(2'd2, 8'h00);

        // R10 slave mode, both polarities
        for (int cp = 0; cp < 2; cp++) begin
            b = (cp != 0) ? 8'h4D : 8'hB4;
            sck_in  = cp[0];
            cs_n_in = 1'b1;
            idle(6);
            wr(2'd0, ctrl_byte(1'b0, 1'b0, 3'd0, cp[0], 1'b0, 1'b1));
            wr(2'd1, b);
            idle(4);
            for (int k = 0; k < 2; k++) begin
                sck_in = !cp[0];
                idle(8);
                sck_in = cp[0];
                idle(8);
            end
            check("R10 no end with select high", int'(end_flag), 0);
            cs_n_in = 1'b0;
            idle(4);
            sl = '0;
            for (int k = 0; k < 8; k++) begin
                sck_in = !cp[0];
                idle(8);
                check("R10 sck output held", int'(sck_out), cp);
                sl = {sl[6:0], sdo_out};
                sck_in = cp[0];
                idle(8);
            end
            idle(4);
            cs_n_in = 1'b1;
            check("R10 slave byte", int'(sl), int'(b));
            check("R10 end flag", int'(end_flag), 1);
            wr(2'd2, 8'h00);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule